// File: doc/BRIEF.md
# Three-Phase Dropout Supervisor

This block supervises the three voltage phases of a polyphase metering front end. Per-phase zero-crossing timeout events and voltage sag events arrive as single-cycle pulses. Each pulse whose enable bit is set is recorded as a pending flag, and any pending flag raises an interrupt. A small control machine then takes all pending flags in one read-and-clear step and works out which phases were lost. It then updates two control fields. The first is a 2-bit field that selects which phase the line-frequency measurement follows. The second is a 3-bit field that says which phases take part in zero-crossing counting.

When the phase that drives frequency measurement is lost, the selector moves to the first healthy phase in a fixed search order. Every lost phase is removed from the zero-crossing set. Only software puts a phase back. Software uses a two-word register port: an enable word that chooses which events are recorded, and a mode word that carries the select and enable fields plus a read-only flag. That flag reports that no phase was left to move to.

Top module: `phase_loss_supervisor`

## Requirements
- R1: After reset the selector reads 00 (phase A), the zero-crossing enable field reads 111, the event enable word reads 0, and both the all-lost flag and the interrupt are low.
- R2: Address 0 holds the event enable word. Bit i (i = 0, 1, 2 for A, B, C) enables sag events of phase i, and bit 3+i enables timeout events of phase i. An event whose enable bit is clear is not recorded, raises no interrupt and changes no output.
- R3: Address 1 holds the mode word. Bits [1:0] are the selector (00 = A, 01 = B, 10 = C), bits [5:3] enable zero-crossing counting for A, B and C, bit 7 is the read-only all-lost flag, and the other bits read 0. A write loads the enable field and clears the flag. It loads the selector unless the written selector is 11, in which case the selector is kept.
- R4: A recorded event raises the interrupt on the edge where it is sampled. On the next edge the controller captures every pending flag and clears them, so the interrupt falls. On the edge after that the two control fields take their new values.
- R5: A phase counts as lost when its sag flag or its timeout flag was captured. Either flag alone is enough.
- R6: After a service, every lost phase has its zero-crossing enable bit cleared, and every other enable bit keeps its value.
- R7: When the selected phase is lost, the selector moves to the first of A, B, C whose enable bit is still set after the update in R6. When the selected phase is not lost, the selector does not change.
- R8: When the selected phase is lost and no enable bit is left set, the selector keeps its value and the all-lost flag is set.
- R9: The controller never sets a zero-crossing enable bit. Only a software write to the mode word sets one.
- R10: The selector output never takes the value 11.
- R11: If a software write to the mode word lands on the same edge as a controller update, the controller update is kept and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sag_ev | input | 3 | Sag event pulses, bit 0 = A, 1 = B, 2 = C |
| zto_ev | input | 3 | Zero-crossing timeout event pulses, same bit order |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 = event enable, 1 = mode) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational on cfg_addr |
| irq | output | 1 | High while any recorded flag is pending |
| freq_sel | output | 2 | Phase that drives frequency measurement |
| zx_en | output | 3 | Phases enabled for zero-crossing counting |
| all_lost | output | 1 | Selected phase lost with no replacement left |

## Verification
The assertions assume that the selector register never holds 11, so the lost-phase lookup always indexes a real phase. They also assume that a software write is the only path that sets an enable bit, which is what lets an unexpected rise be flagged. The stimulus drives events only while the controller is idle, except for one deliberate collision case. Each sweep case starts with a mode write, so no flag and no pending event carries over from the previous case. All mode writes in the sweep use legal selector values, except the writes that check that 11 is refused.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int NPH     = 3;
  localparam int SEL_W   = 2;
  localparam int WORD_W  = 8;
  localparam int ZX_LSB  = 3;
  localparam int FLAG_BIT = 7;
  localparam logic [1:0] ADDR_EVEN = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_BAD = 2'b11;

  typedef struct packed {
    logic [NPH-1:0] zto;
    logic [NPH-1:0] sag;
  } flags_t;

  typedef enum logic {ST_IDLE, ST_APPLY} st_t;
endpackage

// File: rtl/pls_event_latch.sv
module pls_event_latch
  import pls_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t ev,
  input  flags_t ev_en,
  input  logic   clr,
  output flags_t pend
);
  flags_t pend_q, pend_d, ev_m;

  always_comb begin
    ev_m   = ev & ev_en;
    pend_d = (clr ? flags_t'('0) : pend_q) | ev_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R2
  unmasked_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ev_m)) == '0));

  // R4
  event_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_m != '0) |=> ((pend_q & $past(ev_m)) == $past(ev_m)));
endmodule

// File: rtl/pls_phase_pick.sv
module pls_phase_pick
  import pls_pkg::*;
(
  input  logic [NPH-1:0]   cand,
  output logic [SEL_W-1:0] idx,
  output logic             valid
);
  logic [NPH:0]   seen;
  logic [NPH-1:0] hit;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NPH; g++) begin : g_chain
    assign hit[g]    = cand[g] & ~seen[g];
    assign seen[g+1] = seen[g] | cand[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NPH; i++) begin
      if (hit[i]) idx = SEL_W'(i);
    end
  end

  assign valid = seen[NPH];

  // R7
  always_comb begin
    pick_onehot_chk: assert ($onehot0(hit) && (valid == (cand != '0)));
  end
endmodule

// File: rtl/pls_mode_ctrl.sv
module pls_mode_ctrl
  import pls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  flags_t           pend,
  input  logic             mode_we,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NPH-1:0]   wr_en,
  output logic             cap,
  output logic [SEL_W-1:0] freq_sel,
  output logic [NPH-1:0]   zx_en,
  output logic             all_lost
);
  st_t              st_q, st_d;
  flags_t           snap_q, snap_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [NPH-1:0]   en_q, en_d, drop, en_new;
  logic             flag_q, flag_d;
  logic             snap_ce, ctl_ce;
  logic             sel_drop, sel_live;
  logic [SEL_W-1:0] pick_idx;
  logic             pick_ok;

  assign drop   = snap_q.sag | snap_q.zto;
  assign en_new = en_q & ~drop;

  always_comb begin
    case (sel_q)
      2'd0:    sel_drop = drop[0];
      2'd1:    sel_drop = drop[1];
      2'd2:    sel_drop = drop[2];
      default: sel_drop = 1'b0;
    endcase
  end

  pls_phase_pick u_pick (
    .cand  (en_new),
    .idx   (pick_idx),
    .valid (pick_ok)
  );

  always_comb begin
    st_d    = st_q;
    snap_d  = snap_q;
    sel_d   = sel_q;
    en_d    = en_q;
    flag_d  = flag_q;
    cap     = 1'b0;
    snap_ce = 1'b0;
    ctl_ce  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (irq) begin
          cap     = 1'b1;
          snap_d  = pend;
          snap_ce = 1'b1;
          st_d    = ST_APPLY;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_q == ST_APPLY) begin
      ctl_ce = 1'b1;
      en_d   = en_new;
      if (sel_drop) begin
        if (pick_ok) sel_d  = pick_idx;
        else         flag_d = 1'b1;
      end
    end else if (mode_we) begin
      ctl_ce = 1'b1;
      en_d   = wr_en;
      flag_d = 1'b0;
      if (wr_sel != SEL_BAD) sel_d = wr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      snap_q <= '0;
      sel_q  <= '0;
      en_q   <= '1;
      flag_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (snap_ce) snap_q <= snap_d;
      if (ctl_ce) begin
        sel_q  <= sel_d;
        en_q   <= en_d;
        flag_q <= flag_d;
      end
    end
  end

  always_comb begin
    case (sel_q)
      2'd0:    sel_live = en_q[0];
      2'd1:    sel_live = en_q[1];
      2'd2:    sel_live = en_q[2];
      default: sel_live = 1'b0;
    endcase
  end

  assign freq_sel = sel_q;
  assign zx_en    = en_q;
  assign all_lost = flag_q;

  // R10
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q != SEL_BAD);

  // R9
  en_no_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> ((en_q & ~$past(en_q)) == '0));

  // R6
  drop_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_APPLY) |=> ((en_q & $past(drop)) == '0));

  // R7
  sel_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_APPLY && sel_drop) |=> (flag_q || sel_live));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_APPLY && sel_drop && en_new == '0) |=> ($stable(sel_q) && flag_q));

  // R4
  service_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && irq) |=> (st_q == ST_APPLY));
endmodule

// File: rtl/phase_loss_supervisor.sv
module phase_loss_supervisor
  import pls_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPH-1:0]    sag_ev,
  input  logic [NPH-1:0]    zto_ev,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              irq,
  output logic [SEL_W-1:0]  freq_sel,
  output logic [NPH-1:0]    zx_en,
  output logic              all_lost
);
  flags_t ev, ev_en_q, pend;
  logic   en_we, mode_we, cap;
  logic   unused_wbits;

  assign ev.sag  = sag_ev;
  assign ev.zto  = zto_ev;
  assign en_we   = cfg_we && (cfg_addr == ADDR_W'(ADDR_EVEN));
  assign mode_we = cfg_we && (cfg_addr == ADDR_W'(ADDR_MODE));
  assign unused_wbits = ^{cfg_wdata[WORD_W-1:2*NPH], cfg_wdata[ZX_LSB-1:SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_en_q <= '0;
    else if (en_we) ev_en_q <= cfg_wdata[2*NPH-1:0];
  end

  pls_event_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .ev_en (ev_en_q),
    .clr   (cap),
    .pend  (pend)
  );

  assign irq = (pend != '0);

  pls_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .pend     (pend),
    .mode_we  (mode_we),
    .wr_sel   (cfg_wdata[SEL_W-1:0]),
    .wr_en    (cfg_wdata[ZX_LSB+NPH-1:ZX_LSB]),
    .cap      (cap),
    .freq_sel (freq_sel),
    .zx_en    (zx_en),
    .all_lost (all_lost)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_W'(ADDR_EVEN)) begin
      cfg_rdata[2*NPH-1:0] = ev_en_q;
    end else if (cfg_addr == ADDR_W'(ADDR_MODE)) begin
      cfg_rdata[SEL_W-1:0]            = freq_sel;
      cfg_rdata[ZX_LSB+NPH-1:ZX_LSB] = zx_en;
      cfg_rdata[FLAG_BIT]            = all_lost;
    end
  end

  // R4
  irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && $past(ev & ev_en_q) == '0 && (ev & ev_en_q) == '0) |=> !irq);
endmodule

// File: tb/phase_loss_supervisor_tb.sv
module phase_loss_supervisor_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sag_ev = '0, zto_ev = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq, all_lost;
  logic [1:0] freq_sel;
  logic [2:0] zx_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_loss_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .sag_ev(sag_ev), .zto_ev(zto_ev),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .freq_sel(freq_sel),
    .zx_en(zx_en), .all_lost(all_lost)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd1;
  endtask

  task automatic pulse(input logic [2:0] s, input logic [2:0] z);
    @(negedge clk);
    sag_ev = s; zto_ev = z;
    @(negedge clk);
    sag_ev = '0; zto_ev = '0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] mode_word(input logic f, input logic [2:0] e, input logic [1:0] s);
    return {f, 1'b0, 2'b00, 1'b0, 3'b000} | {f, 1'b0, e, 1'b0, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 sel", freq_sel, 0);
    check("R1 zx_en", zx_en, 3'b111);
    check("R1 flag", all_lost, 0);
    check("R1 irq", irq, 0);
    cfg_addr = 2'd0; #1;
    check("R1 even word", cfg_rdata, 0);
    cfg_addr = 2'd1; #1;
    check("R1 mode word", cfg_rdata, 8'h38);

    // R3 selector 11 refused, fields load, readback
    wr(2'd1, 8'h3B); #1;
    check("R3 sel 11 kept", freq_sel, 0);
    check("R3 readback", cfg_rdata, 8'h38);
    wr(2'd1, 8'hCA); #1;
    check("R3 sel load", freq_sel, 2);
    check("R3 en load", zx_en, 3'b001);
    check("R3 readback clean", cfg_rdata, 8'h0A);

    // R2 disabled sag of A ignored, timeout of A still acts (R5)
    wr(2'd0, 8'h3E);
    cfg_addr = 2'd0; #1;
    check("R2 even readback", cfg_rdata, 8'h3E);
    wr(2'd1, 8'h38);
    pulse(3'b001, 3'b000);
    check("R2 irq stays low", irq, 0);
    check("R2 sel unchanged", freq_sel, 0);
    check("R2 en unchanged", zx_en, 3'b111);
    pulse(3'b000, 3'b001);
    check("R5 timeout alone sel", freq_sel, 1);
    check("R5 timeout alone en", zx_en, 3'b110);

    // R4 timing of one service
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'h38);
    @(negedge clk); sag_ev = 3'b001;
    @(negedge clk); sag_ev = 3'b000; #1;
    check("R4 irq raised", irq, 1);
    check("R4 sel before", freq_sel, 0);
    @(negedge clk); #1;
    check("R4 irq cleared", irq, 0);
    check("R4 en before", zx_en, 3'b111);
    @(negedge clk); #1;
    check("R4 sel after", freq_sel, 1);
    check("R4 en after", zx_en, 3'b110);

    // R11 write colliding with controller update
    @(negedge clk); zto_ev = 3'b100;
    @(negedge clk); zto_ev = 3'b000;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 8'h38;
    @(negedge clk); cfg_we = 1'b0;
    repeat (2) @(negedge clk); #1;
    check("R11 en update kept", zx_en, 3'b010);
    check("R11 sel kept", freq_sel, 1);

    // Sweep: R5 R6 R7 R8 R9 R10
    for (int s = 0; s < 3; s++) begin
      for (int e = 0; e < 8; e++) begin
        for (int d = 1; d < 8; d++) begin
          logic [2:0] ne, sv, zv;
          logic [1:0] xs;
          logic xf;
          int src;
          src = (s + e + d) % 3;
          sv = (src != 1) ? 3'(d) : 3'b000;
          zv = (src != 0) ? 3'(d) : 3'b000;
          ne = 3'(e) & ~3'(d);
          xs = 2'(s);
          xf = 1'b0;
          if (d[s]) begin
            if (ne[0])      xs = 2'd0;
            else if (ne[1]) xs = 2'd1;
            else if (ne[2]) xs = 2'd2;
            else            xf = 1'b1;
          end
          wr(2'd1, {2'b00, 3'(e), 1'b0, 2'(s)});
          pulse(sv, zv);
          check("R6 R9 en", zx_en, ne);
          check("R7 R8 sel", freq_sel, xs);
          check("R8 flag", all_lost, xf);
          check("R10 sel legal", freq_sel == 2'b11, 0);
          check("R3 mode readback", cfg_rdata, {xf, 1'b0, ne, 1'b0, xs});
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule